// File: doc/BRIEF.md
# Multiplexed SAR Converter Scan Sequencer

This block sits on the host side of a four-input, 12-bit successive-approximation converter. The converter has a parallel bus with active-low chip-select, write and read strobes, two channel-address lines, a BUSY return and a 12-bit data bus. The sequencer steps through a mask of enabled inputs in ascending order. For each input it places the channel number on the address lines, starts a conversion with a write pulse, follows the BUSY handshake, reads the result with a read pulse and hands it on with its channel tag.

A single start pulse runs one pass over the enabled inputs. Holding the continuous input high makes the block start a new pass straight after the last one ends. If a conversion is never acknowledged, a timeout sets a sticky fault flag and the scan moves to the next input. The block also produces a divided clock that drives the converter.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, chip-select, write strobe and read strobe are all high (inactive), result valid is low and the fault flag is low.
- R2: A start pulse with a nonzero mask converts every enabled input exactly once, in ascending channel order (bit n of the mask enables input n). A start with an all-zero mask is ignored and produces no strobe.
- R3: The write strobe and the read strobe are driven low only while chip-select is low, and never both in the same cycle.
- R4: The address lines carry the channel number. They are driven for at least ADDR_SETUP cycles (at least one) before the write strobe falls, and they do not change while the strobe is low or in the cycle it rises.
- R5: Every write and read low pulse lasts max(strobe_len, 2) system clocks.
- R6: A read starts only after BUSY has been seen low and then high again. The data bus is sampled in the last cycle of the read pulse, so whatever the bus carries outside the read pulse never reaches the result.
- R7: Each result is presented on res_data (bit 11 is the most significant bit, passed through unchanged), with its channel on res_chan, for exactly one cycle of res_valid.
- R8: If BUSY stays high for max(busy_timeout, 1) cycles after the write strobe rises, the fault flag is set. No read is issued for that input and no result is produced, and the scan continues with the next enabled input.
- R9: While cont_mode is high, passes repeat without a new start. When it drops, the current pass ends and the bus stays idle.
- R10: adc_clk toggles every CONV_DIV system clocks.
- R11: Once set, the fault flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts one scan pass while idle |
| cont_mode | input | 1 | Repeat passes while high |
| ch_mask | input | NCH | Enabled inputs, bit n = input n |
| strobe_len | input | PW_W | Low-pulse length of write/read, minimum 2 applied |
| busy_timeout | input | TO_W | Cycles to wait for BUSY to fall |
| busy_n | input | 1 | Converter BUSY, low while converting |
| adc_data | input | DATA_W | Converter data bus |
| adc_cs_n | output | 1 | Chip-select, active low |
| adc_wr_n | output | 1 | Write strobe, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_addr | output | CH_W | Channel address |
| adc_clk | output | 1 | Divided conversion clock |
| res_data | output | DATA_W | Captured result |
| res_chan | output | CH_W | Channel tag of the result |
| res_valid | output | 1 | One-cycle result strobe |
| err_timeout | output | 1 | Sticky BUSY timeout fault |

## Verification
The assertions assume that the converter lowers BUSY only after a write pulse and raises it again before the sequencer reads. They also assume that BUSY and the configuration inputs are stable around the clock edge, and that strobe_len and the mask do not change during a pass. The bench's converter model reacts only to a completed write pulse and changes BUSY and the data bus on the falling clock edge. It changes configuration only while the bus is idle. Outside read pulses it drives a fixed junk pattern on the data bus, so a sample taken at the wrong time shows up as a wrong result.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SET_ADDR,
        S_WR_PULSE,
        S_WAIT_BUSY_LO,
        S_WAIT_BUSY_HI,
        S_RD_PULSE,
        S_CAPTURE,
        S_NEXT_CH
    } scan_state_e;

    localparam int MIN_STROBE = 2;

endpackage

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic [NCH-1:0]  live_mask,
    input  logic [NCH-1:0]  pass_mask,
    input  logic [CH_W-1:0] cur_ch,
    output logic [CH_W-1:0] first_ch,
    output logic            first_ok,
    output logic [CH_W-1:0] next_ch,
    output logic            next_ok
);

    logic [NCH-1:0] above;

    // Candidate vector: enabled channels strictly above the current one
    for (genvar g = 0; g < NCH; g++) begin : g_above
        assign above[g] = pass_mask[g] && (g > int'(cur_ch));
    end

    // Lowest set bit wins: scan downward so the last hit is the lowest
    always_comb begin
        first_ok = 1'b0;
        first_ch = '0;
        next_ok  = 1'b0;
        next_ch  = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (live_mask[i]) begin
                first_ok = 1'b1;
                first_ch = CH_W'(i);
            end
            if (above[i]) begin
                next_ok = 1'b1;
                next_ch = CH_W'(i);
            end
        end
    end

endmodule

// File: rtl/adc_conv_clk.sv
module adc_conv_clk #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic clk_out
);

    if (DIV <= 1) begin : g_toggle
        logic tgl_d, tgl_q;
        always_comb tgl_d = ~tgl_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tgl_q <= 1'b0;
            else        tgl_q <= tgl_d;
        end
        assign clk_out = tgl_q;
    end else begin : g_count
        localparam int DW = $clog2(DIV);
        localparam logic [DW-1:0] LAST = DW'(DIV - 1);

        typedef struct packed {
            logic [DW-1:0] cnt;
            logic          lvl;
        } div_t;

        div_t div_d, div_q;

        always_comb begin
            div_d = div_q;
            if (div_q.cnt == LAST) begin
                div_d.cnt = '0;
                div_d.lvl = ~div_q.lvl;
            end else begin
                div_d.cnt = div_q.cnt + DW'(1);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) div_q <= '0;
            else        div_q <= div_d;
        end

        assign clk_out = div_q.lvl;

        // R10: output level only moves on a wrap of the counter
        a_r10_toggle_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (div_q.lvl != $past(div_q.lvl)) |-> (div_q.cnt == '0));
    end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int CH_W       = 2,
    parameter int DATA_W     = 12,
    parameter int PW_W       = 4,
    parameter int TO_W       = 8,
    parameter int ADDR_SETUP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cont_mode,
    input  logic [NCH-1:0]    ch_mask,
    input  logic [PW_W-1:0]   strobe_len,
    input  logic [TO_W-1:0]   busy_timeout,
    input  logic              busy_n,
    input  logic [DATA_W-1:0] adc_data,
    output logic              cs_n,
    output logic              wr_n,
    output logic              rd_n,
    output logic [CH_W-1:0]   addr,
    output logic [DATA_W-1:0] res_data,
    output logic [CH_W-1:0]   res_chan,
    output logic              res_valid,
    output logic              err
);

    localparam int SETUP_EFF = (ADDR_SETUP < 1) ? 1 : ADDR_SETUP;
    localparam int SU_W      = $clog2(SETUP_EFF + 1);
    localparam int MX_A      = (PW_W > TO_W) ? PW_W : TO_W;
    localparam int CNT_W     = (MX_A > SU_W) ? MX_A : SU_W;
    localparam logic [CNT_W-1:0] SETUP_M1 = CNT_W'(SETUP_EFF - 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    typedef struct packed {
        scan_state_e       st;
        logic [CH_W-1:0]   ch;
        logic [NCH-1:0]    mask;
        logic [CNT_W-1:0]  cnt;
        logic              cs_n;
        logic              wr_n;
        logic              rd_n;
        logic [DATA_W-1:0] data;
        logic [CH_W-1:0]   tag;
        logic              valid;
        logic              err;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st:    S_IDLE,
        ch:    '0,
        mask:  '0,
        cnt:   '0,
        cs_n:  1'b1,
        wr_n:  1'b1,
        rd_n:  1'b1,
        data:  '0,
        tag:   '0,
        valid: 1'b0,
        err:   1'b0
    };

    seq_t q, d;

    logic [CH_W-1:0]  first_ch, next_ch;
    logic             first_ok, next_ok;
    logic [CNT_W-1:0] pulse_m1;
    logic [CNT_W-1:0] to_m1;

    adc_chan_pick #(
        .NCH  (NCH),
        .CH_W (CH_W)
    ) i_pick (
        .live_mask (ch_mask),
        .pass_mask (q.mask),
        .cur_ch    (q.ch),
        .first_ch  (first_ch),
        .first_ok  (first_ok),
        .next_ch   (next_ch),
        .next_ok   (next_ok)
    );

    // Effective strobe length and timeout, both as "last count" values
    always_comb begin
        if (int'(strobe_len) < MIN_STROBE) pulse_m1 = CNT_W'(MIN_STROBE - 1);
        else                               pulse_m1 = CNT_W'(strobe_len) - ONE;
        if (busy_timeout == '0) to_m1 = '0;
        else                    to_m1 = CNT_W'(busy_timeout) - ONE;
    end

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start && first_ok) begin
                    d.st   = S_SET_ADDR;
                    d.ch   = first_ch;
                    d.mask = ch_mask;
                    d.cnt  = SETUP_M1;
                end
            end
            S_SET_ADDR: begin
                if (q.cnt == '0) begin
                    d.st  = S_WR_PULSE;
                    d.cnt = pulse_m1;
                end else begin
                    d.cnt = q.cnt - ONE;
                end
            end
            S_WR_PULSE: begin
                if (q.cnt == '0) begin
                    d.st  = S_WAIT_BUSY_LO;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt - ONE;
                end
            end
            S_WAIT_BUSY_LO: begin
                if (!busy_n) begin
                    d.st = S_WAIT_BUSY_HI;
                end else if (q.cnt >= to_m1) begin
                    d.err = 1'b1;
                    d.st  = S_NEXT_CH;
                end else begin
                    d.cnt = q.cnt + ONE;
                end
            end
            S_WAIT_BUSY_HI: begin
                if (busy_n) begin
                    d.st  = S_RD_PULSE;
                    d.cnt = pulse_m1;
                end
            end
            S_RD_PULSE: begin
                if (q.cnt == '0) begin
                    d.st    = S_CAPTURE;
                    d.data  = adc_data;
                    d.tag   = q.ch;
                    d.valid = 1'b1;
                end else begin
                    d.cnt = q.cnt - ONE;
                end
            end
            S_CAPTURE: begin
                d.st = S_NEXT_CH;
            end
            S_NEXT_CH: begin
                if (next_ok) begin
                    d.st  = S_SET_ADDR;
                    d.ch  = next_ch;
                    d.cnt = SETUP_M1;
                end else if (cont_mode && first_ok) begin
                    d.st   = S_SET_ADDR;
                    d.ch   = first_ch;
                    d.mask = ch_mask;
                    d.cnt  = SETUP_M1;
                end else begin
                    d.st = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
        // Registered strobes follow the next state, so they leave the flops glitch-free
        d.wr_n = (d.st != S_WR_PULSE);
        d.rd_n = (d.st != S_RD_PULSE);
        d.cs_n = (d.st != S_WR_PULSE) && (d.st != S_RD_PULSE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    assign cs_n      = q.cs_n;
    assign wr_n      = q.wr_n;
    assign rd_n      = q.rd_n;
    assign addr      = q.ch;
    assign res_data  = q.data;
    assign res_chan  = q.tag;
    assign res_valid = q.valid;
    assign err       = q.err;

    // R3: strobes qualified by chip-select, never overlapping
    a_r3_wr_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !cs_n);
    a_r3_rd_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !cs_n);
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wr_n && !rd_n));
    // R4: address set up before the write pulse and held through its rising edge
    a_r4_addr_hold_wr: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> $stable(addr));
    a_r4_addr_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> $stable(addr));
    // R5: no strobe shorter than two cycles
    a_r5_wr_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> ($past(wr_n, 1) == 1'b0 && $past(wr_n, 2) == 1'b0));
    a_r5_rd_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> ($past(rd_n, 1) == 1'b0 && $past(rd_n, 2) == 1'b0));
    // R6: a read only follows a BUSY that was high one cycle earlier
    a_r6_rd_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> $past(busy_n));
    // R7: result strobe is a single cycle and follows a read pulse
    a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    a_r7_valid_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> $rose(rd_n));
    // R11: fault flag never clears while out of reset
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
    parameter int NCH        = 4,
    parameter int DATA_W     = 12,
    parameter int PW_W       = 4,
    parameter int TO_W       = 8,
    parameter int ADDR_SETUP = 1,
    parameter int CONV_DIV   = 4,
    localparam int CH_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cont_mode,
    input  logic [NCH-1:0]    ch_mask,
    input  logic [PW_W-1:0]   strobe_len,
    input  logic [TO_W-1:0]   busy_timeout,
    input  logic              busy_n,
    input  logic [DATA_W-1:0] adc_data,
    output logic              adc_cs_n,
    output logic              adc_wr_n,
    output logic              adc_rd_n,
    output logic [CH_W-1:0]   adc_addr,
    output logic              adc_clk,
    output logic [DATA_W-1:0] res_data,
    output logic [CH_W-1:0]   res_chan,
    output logic              res_valid,
    output logic              err_timeout
);

    adc_scan_seq #(
        .NCH        (NCH),
        .CH_W       (CH_W),
        .DATA_W     (DATA_W),
        .PW_W       (PW_W),
        .TO_W       (TO_W),
        .ADDR_SETUP (ADDR_SETUP)
    ) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .cont_mode    (cont_mode),
        .ch_mask      (ch_mask),
        .strobe_len   (strobe_len),
        .busy_timeout (busy_timeout),
        .busy_n       (busy_n),
        .adc_data     (adc_data),
        .cs_n         (adc_cs_n),
        .wr_n         (adc_wr_n),
        .rd_n         (adc_rd_n),
        .addr         (adc_addr),
        .res_data     (res_data),
        .res_chan     (res_chan),
        .res_valid    (res_valid),
        .err          (err_timeout)
    );

    adc_conv_clk #(
        .DIV (CONV_DIV)
    ) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_out (adc_clk)
    );

endmodule

// File: tb/test_adc_scan_ctrl.sv
`timescale 1ns/1ps
module test_adc_scan_ctrl;

    localparam int DIV  = 4;
    localparam int LAT  = 2;   // model: negedges from write rise to BUSY low
    localparam int CONV = 6;   // model: negedges BUSY stays low
    localparam int LOGN = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cont_mode = 1'b0;
    logic [3:0]  ch_mask = 4'b0000;
    logic [3:0]  strobe_len = 4'd2;
    logic [7:0]  busy_timeout = 8'd16;
    logic        busy_n = 1'b1;
    logic [11:0] adc_data;
    logic        adc_cs_n, adc_wr_n, adc_rd_n, adc_clk;
    logic [1:0]  adc_addr;
    logic [11:0] res_data;
    logic [1:0]  res_chan;
    logic        res_valid, err_timeout;

    always #2 clk = ~clk;

    adc_scan_ctrl #(.CONV_DIV(DIV)) i_adc_scan_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cont_mode(cont_mode),
        .ch_mask(ch_mask), .strobe_len(strobe_len), .busy_timeout(busy_timeout),
        .busy_n(busy_n), .adc_data(adc_data), .adc_cs_n(adc_cs_n),
        .adc_wr_n(adc_wr_n), .adc_rd_n(adc_rd_n), .adc_addr(adc_addr),
        .adc_clk(adc_clk), .res_data(res_data), .res_chan(res_chan),
        .res_valid(res_valid), .err_timeout(err_timeout)
    );

    // ---------------- converter model and bus monitor ----------------
    logic [3:0]  dead_mask = 4'b0000;
    logic [11:0] conv_val = 12'h000;
    logic [1:0]  latched = 2'd0;
    logic [1:0]  addr_at_fall = 2'd0;
    int          seq = 0;
    int          ph = 0, mcnt = 0;
    logic        prev_wr = 1'b1, prev_rd = 1'b1, prev_valid = 1'b0;
    int          wr_run = 0, rd_run = 0;
    int          last_wr_w = 0, last_rd_w = 0;
    int          wr_cnt = 0, rd_cnt = 0, res_cnt = 0, long_cnt = 0, addr_bad = 0;
    logic [1:0]  wr_log [LOGN];
    logic [11:0] rdat_log [LOGN];
    logic [1:0]  rch_log [LOGN];

    assign adc_data = (!adc_cs_n && !adc_rd_n) ? conv_val : 12'hBAD;

    always @(negedge clk) begin
        if (!rst_n) begin
            busy_n  <= 1'b1;
            ph      <= 0;
            prev_wr <= 1'b1;
            prev_rd <= 1'b1;
            wr_run  <= 0;
            rd_run  <= 0;
        end else begin
            if (prev_wr && !adc_wr_n) addr_at_fall <= adc_addr;
            if (!prev_wr && adc_wr_n) begin
                last_wr_w <= wr_run;
                if (addr_at_fall != adc_addr) addr_bad <= addr_bad + 1;
                if (wr_cnt < LOGN) wr_log[wr_cnt] <= adc_addr;
                wr_cnt  <= wr_cnt + 1;
                latched <= adc_addr;
                if (!dead_mask[adc_addr]) begin
                    ph   <= 1;
                    mcnt <= LAT;
                end
            end
            if (!prev_rd && adc_rd_n) begin
                last_rd_w <= rd_run;
                rd_cnt    <= rd_cnt + 1;
            end
            wr_run  <= adc_wr_n ? 0 : wr_run + 1;
            rd_run  <= adc_rd_n ? 0 : rd_run + 1;
            prev_wr <= adc_wr_n;
            prev_rd <= adc_rd_n;
            if (ph == 1) begin
                if (mcnt <= 1) begin busy_n <= 1'b0; ph <= 2; mcnt <= CONV; end
                else mcnt <= mcnt - 1;
            end else if (ph == 2) begin
                if (mcnt <= 1) begin
                    busy_n   <= 1'b1;
                    conv_val <= {latched, 10'(seq)};
                    seq      <= seq + 1;
                    ph       <= 0;
                end else mcnt <= mcnt - 1;
            end
        end
    end

    always @(negedge clk) begin
        if (res_valid) begin
            if (res_cnt < LOGN) begin
                rdat_log[res_cnt] <= res_data;
                rch_log[res_cnt]  <= res_chan;
            end
            res_cnt <= res_cnt + 1;
            if (prev_valid) long_cnt <= long_cnt + 1;
        end
        prev_valid <= res_valid;
    end

    // ---------------- checking ----------------
    int n_chk = 0, n_fail = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic t_reset_state(input string req);
        check(req, "cs_n after reset", adc_cs_n, 1);
        check(req, "wr_n after reset", adc_wr_n, 1);
        check(req, "rd_n after reset", adc_rd_n, 1);
        check(req, "valid after reset", res_valid, 0);
        check(req, "err after reset", err_timeout, 0);
    endtask

    // One pass with a given mask, strobe length and set of silent inputs
    task automatic t_pass(input logic [3:0] m, input logic [3:0] len, input logic [3:0] dead);
        int bw, br, bs, bl, brd, n_en, n_live, w;
        int ch_list [4];
        int live_list [4];
        ch_mask = m; strobe_len = len; dead_mask = dead;
        bw = wr_cnt; br = res_cnt; bs = seq; bl = long_cnt; brd = rd_cnt;
        n_en = 0; n_live = 0;
        for (int c = 0; c < 4; c++) begin
            if (m[c]) begin
                ch_list[n_en] = c; n_en++;
                if (!dead[c]) begin live_list[n_live] = c; n_live++; end
            end
        end
        w = (len < 2) ? 2 : int'(len);
        pulse_start();
        repeat (400) @(negedge clk);
        check("R2", "conversions started", wr_cnt - bw, n_en);
        for (int i = 0; i < n_en; i++)
            check("R4", "address at write rise", wr_log[bw + i], ch_list[i]);
        check("R4", "address changed under write", addr_bad, 0);
        check("R8", "results produced", res_cnt - br, n_live);
        check("R8", "reads issued", rd_cnt - brd, n_live);
        for (int i = 0; i < n_live; i++) begin
            check("R7", "result channel tag", rch_log[br + i], live_list[i]);
            check("R6", "result data", rdat_log[br + i], {live_list[i][1:0], 10'(bs + i)});
        end
        if (n_en > 0) check("R5", "write pulse width", last_wr_w, w);
        if (n_live > 0) check("R5", "read pulse width", last_rd_w, w);
        check("R7", "valid longer than a cycle", long_cnt - bl, 0);
        check("R9", "bus idle after single pass", adc_cs_n, 1);
    endtask

    task automatic t_cont();
        int br, got, guard, wr_hold;
        ch_mask = 4'b1010; strobe_len = 4'd3; dead_mask = 4'b0000;
        br = res_cnt;
        cont_mode = 1'b1;
        pulse_start();
        guard = 0;
        while (res_cnt - br < 6 && guard < 3000) begin
            @(negedge clk); guard++;
        end
        cont_mode = 1'b0;
        repeat (300) @(negedge clk);
        got = res_cnt - br;
        check("R9", "at least three passes", (got >= 6) ? 1 : 0, 1);
        check("R9", "whole passes only", got % 2, 0);
        for (int i = 0; i < 6; i++)
            check("R9", "channel order across passes", rch_log[br + i], (i % 2) ? 3 : 1);
        wr_hold = wr_cnt;
        repeat (100) @(negedge clk);
        check("R9", "no strobe after mode drop", wr_cnt - wr_hold, 0);
    endtask

    task automatic t_clkdiv();
        logic lvl;
        int gap, guard;
        lvl = adc_clk; guard = 0;
        while (adc_clk == lvl && guard < 50) begin @(negedge clk); guard++; end
        lvl = adc_clk; gap = 0;
        while (adc_clk == lvl && gap < 50) begin @(negedge clk); gap++; end
        check("R10", "conversion clock half period", gap, DIV);
    endtask

    // ---------------- sequence ----------------
    initial begin
        do_reset();
        t_reset_state("R1");
        t_clkdiv();
        t_pass(4'b1111, 4'd2, 4'b0000);          // R2 full mask, minimum width
        t_pass(4'b1010, 4'd5, 4'b0000);          // R2 skip disabled inputs
        t_pass(4'b0001, 4'd0, 4'b0000);          // R5 length below minimum -> 2
        t_pass(4'b0000, 4'd3, 4'b0000);          // R2 empty mask ignored
        check("R8", "no fault before timeout case", err_timeout, 0);
        busy_timeout = 8'd8;
        t_pass(4'b1111, 4'd4, 4'b0100);          // R8 input 2 never acknowledges
        check("R8", "fault set on timeout", err_timeout, 1);
        t_pass(4'b1001, 4'd3, 4'b0000);          // R11 clean pass keeps fault
        check("R11", "fault still set", err_timeout, 1);
        busy_timeout = 8'd16;
        t_cont();
        do_reset();
        t_reset_state("R11");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule